// File: doc/BRIEF.md
# Scoreboard Issue and Hazard Controller

This block decides, one instruction at a time, when a decoded operation may be handed to one of five functional units, and when each of those units may begin its work. Two kinds of conflict hold an instruction at the issue point: the target unit is still reserved, or the destination register is still waiting for an earlier, unfinished result. A missing source operand does not hold issue. Instead, the unit is reserved at once and records which unit will produce each missing operand. It starts in the very cycle that producer reports completion.

A branch takes the branch unit and freezes issue until that unit finishes. The arithmetic datapaths are not built here. Each unit is a fixed-latency counter that reports start and done, so the control timing can be studied and reused around real datapaths.

The decoder presents an instruction with `in_valid` and holds it steady while `issue_stall` is high. The instruction is accepted at the first rising edge at which `issue_stall` is low.

Top module: `sb_scoreboard`

## Requirements
- R1: An instruction whose target unit is reserved is held (`issue_stall` high) until the cycle after that unit's `fu_done` pulse, and it is accepted at the next edge. The two multipliers (unit indices 0 and 1) are reserved independently, so one can take an instruction while the other is busy.
- R2: A non-branch instruction whose destination register is reserved by an unfinished instruction is held until the cycle after the producing unit's `fu_done`. The destination field of a branch is ignored: it neither blocks issue nor reserves a register.
- R3: A source register that still awaits a result does not stall issue. An instruction with no conflict is accepted at the edge that follows its presentation, and at most one instruction is accepted per edge.
- R4: A unit whose source operands are both available when it issues raises `fu_start` in the cycle right after the accepting edge.
- R5: A unit waiting on an operand raises `fu_start` in the same cycle that the producing unit raises `fu_done`, with no extra cycle.
- R6: A valid instruction with `in_br` high goes to the branch unit (index 4) whatever `in_fu` holds. After it is accepted, every instruction is held until the cycle after the branch unit's `fu_done`.
- R7: Each unit raises `fu_done` for one cycle, exactly its latency after its `fu_start`. The default latencies are 10 for each multiplier, 16 for the divider (index 2), 4 for the floating adder (index 3) and 2 for the branch unit (index 4).
- R8: A source register is treated as available when the instruction that reads it is accepted at the edge that ends the producer's `fu_done` cycle.
- R9: After reset, `issue_stall`, `fu_start` and `fu_done` are all low, and a presented instruction is not stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A decoded instruction is presented |
| in_br | input | 1 | Presented instruction is a branch |
| in_fu | input | 3 | Target unit index (ignored for branches) |
| in_dst | input | 3 | Destination register |
| in_src1 | input | 3 | First source register |
| in_src2 | input | 3 | Second source register |
| issue_stall | output | 1 | Presented instruction cannot be accepted this cycle |
| fu_start | output | 5 | Per-unit pulse: unit begins executing |
| fu_done | output | 5 | Per-unit pulse: unit completes and releases its result |

## Verification
The assertions assume that the decoder holds a stalled instruction steady, and that `in_fu` names an existing unit (0 to 4) whenever a non-branch instruction is valid. They also assume that reset is applied from time zero. The bench drives only unit indices 0 to 4 and keeps `in_valid` and the fields constant until the instruction is accepted. It leaves enough idle cycles between scenarios for every unit to drain, so each scenario starts from an empty scoreboard.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NUM_FU   = 5;
  localparam int NUM_REGS = 8;
  localparam int FU_W     = 3;
  localparam int REG_W    = $clog2(NUM_REGS);
  localparam int FU_SPAN  = 1 << FU_W;

  localparam int FU_MUL0 = 0;
  localparam int FU_MUL1 = 1;
  localparam int FU_DIV  = 2;
  localparam int FU_FADD = 3;
  localparam int FU_BR   = 4;

  // latency of a unit slot, chosen from the per-kind parameters
  function automatic int unit_latency(input int idx, input int mul_l,
                                      input int div_l, input int fadd_l,
                                      input int br_l);
    if (idx == FU_MUL0 || idx == FU_MUL1) return mul_l;
    else if (idx == FU_DIV)               return div_l;
    else if (idx == FU_FADD)              return fadd_l;
    else                                  return br_l;
  endfunction
endpackage

// File: rtl/sb_reg_status.sv
module sb_reg_status
  import sb_pkg::*;
#(
  parameter int N_REGS = NUM_REGS,
  parameter int N_FU   = NUM_FU,
  parameter int TAG_W  = FU_W,
  parameter int RIDX_W = REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic [RIDX_W-1:0] set_reg,
  input  logic [TAG_W-1:0]  set_fu,
  input  logic [N_FU-1:0]   done_all,
  input  logic [RIDX_W-1:0] look1_reg,
  input  logic [RIDX_W-1:0] look2_reg,
  output logic              look1_wait,
  output logic [TAG_W-1:0]  look1_prod,
  output logic              look2_wait,
  output logic [TAG_W-1:0]  look2_prod,
  output logic [N_REGS-1:0] reg_pend
);
  localparam int SPAN = 1 << TAG_W;

  logic [N_REGS-1:0] pend_q;
  logic [TAG_W-1:0]  tag_q [N_REGS];
  logic [SPAN-1:0]   dpad;
  logic [N_REGS-1:0] release_now;

  assign dpad = SPAN'(done_all);

  genvar r;
  generate
    for (r = 0; r < N_REGS; r++) begin : g_rel
      assign release_now[r] = pend_q[r] & dpad[tag_q[r]];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      for (int i = 0; i < N_REGS; i++) tag_q[i] <= '0;
    end else begin
      for (int i = 0; i < N_REGS; i++) begin
        if (release_now[i]) pend_q[i] <= 1'b0;
      end
      if (set_en) begin
        pend_q[set_reg] <= 1'b1;
        tag_q[set_reg]  <= set_fu;
      end
    end
  end

  // a source completing in this very cycle counts as available
  assign look1_wait = pend_q[look1_reg] & ~dpad[tag_q[look1_reg]];
  assign look2_wait = pend_q[look2_reg] & ~dpad[tag_q[look2_reg]];
  assign look1_prod = tag_q[look1_reg];
  assign look2_prod = tag_q[look2_reg];
  assign reg_pend   = pend_q;

  assert_no_double_reserve_R2: assert property (@(posedge clk) disable iff (rst)
    set_en |-> !pend_q[set_reg]);

  generate
    for (r = 0; r < N_REGS; r++) begin : g_chk
      assert_release_on_done_R2: assert property (@(posedge clk) disable iff (rst)
        release_now[r] |=> !pend_q[r]);
    end
  endgenerate
endmodule

// File: rtl/sb_unit_slot.sv
module sb_unit_slot
  import sb_pkg::*;
#(
  parameter int LAT   = 4,
  parameter int N_FU  = NUM_FU,
  parameter int TAG_W = FU_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic             wait1,
  input  logic [TAG_W-1:0] prod1,
  input  logic             wait2,
  input  logic [TAG_W-1:0] prod2,
  input  logic [N_FU-1:0]  done_all,
  output logic             busy,
  output logic             start,
  output logic             done
);
  localparam int SPAN  = 1 << TAG_W;
  localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1;

  logic             busy_q, run_q, rdy1_q, rdy2_q;
  logic [TAG_W-1:0] prod1_q, prod2_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SPAN-1:0]  dpad;
  logic             rdy1_now, rdy2_now;

  assign dpad     = SPAN'(done_all);
  assign rdy1_now = rdy1_q | dpad[prod1_q];
  assign rdy2_now = rdy2_q | dpad[prod2_q];
  assign start    = busy_q & ~run_q & rdy1_now & rdy2_now;
  assign done     = run_q & (cnt_q == '0);
  assign busy     = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      run_q   <= 1'b0;
      rdy1_q  <= 1'b0;
      rdy2_q  <= 1'b0;
      prod1_q <= '0;
      prod2_q <= '0;
      cnt_q   <= '0;
    end else if (issue) begin
      busy_q  <= 1'b1;
      run_q   <= 1'b0;
      rdy1_q  <= ~wait1;
      rdy2_q  <= ~wait2;
      prod1_q <= prod1;
      prod2_q <= prod2;
    end else begin
      if (done) begin
        busy_q <= 1'b0;
        run_q  <= 1'b0;
      end
      if (start) begin
        run_q <= 1'b1;
        cnt_q <= CNT_W'(LAT - 1);
      end else if (run_q && cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (busy_q && !rdy1_q && dpad[prod1_q]) rdy1_q <= 1'b1;
      if (busy_q && !rdy2_q && dpad[prod2_q]) rdy2_q <= 1'b1;
    end
  end

  assert_issue_to_idle_R1: assert property (@(posedge clk) disable iff (rst)
    issue |-> !busy_q);

  assert_start_reserved_R4: assert property (@(posedge clk) disable iff (rst)
    start |-> (busy_q && !done));

  assert_run_after_start_R7: assert property (@(posedge clk) disable iff (rst)
    start |=> (run_q && busy_q));

  assert_done_frees_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy_q);
endmodule

// File: rtl/sb_issue_ctl.sv
module sb_issue_ctl
  import sb_pkg::*;
#(
  parameter int N_FU   = NUM_FU,
  parameter int N_REGS = NUM_REGS,
  parameter int TAG_W  = FU_W,
  parameter int RIDX_W = REG_W,
  parameter int BR_IDX = FU_BR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_br,
  input  logic [TAG_W-1:0]  in_fu,
  input  logic [RIDX_W-1:0] in_dst,
  input  logic [N_FU-1:0]   unit_busy,
  input  logic [N_REGS-1:0] reg_pend,
  input  logic              br_done,
  output logic              stall,
  output logic              fire,
  output logic              writes_reg,
  output logic [TAG_W-1:0]  tgt_fu,
  output logic [N_FU-1:0]   fire_vec
);
  localparam int SPAN = 1 << TAG_W;

  logic            br_pend_q;
  logic [SPAN-1:0] bpad;
  logic            conflict;

  assign bpad       = SPAN'(unit_busy);
  assign tgt_fu     = in_br ? TAG_W'(BR_IDX) : in_fu;
  assign conflict   = br_pend_q | bpad[tgt_fu] | (~in_br & reg_pend[in_dst]);
  assign stall      = in_valid & conflict;
  assign fire       = in_valid & ~conflict;
  assign writes_reg = fire & ~in_br;

  genvar g;
  generate
    for (g = 0; g < N_FU; g++) begin : g_sel
      assign fire_vec[g] = fire & (tgt_fu == TAG_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                br_pend_q <= 1'b0;
    else if (fire && in_br) br_pend_q <= 1'b1;
    else if (br_done)       br_pend_q <= 1'b0;
  end

  assert_branch_freeze_R6: assert property (@(posedge clk) disable iff (rst)
    br_pend_q |-> !fire);

  assert_branch_sets_freeze_R6: assert property (@(posedge clk) disable iff (rst)
    (fire && in_br) |=> br_pend_q);
endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard
  import sb_pkg::*;
#(
  parameter int MUL_LAT  = 10,
  parameter int DIV_LAT  = 16,
  parameter int FADD_LAT = 4,
  parameter int BR_LAT   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_br,
  input  logic [FU_W-1:0]   in_fu,
  input  logic [REG_W-1:0]  in_dst,
  input  logic [REG_W-1:0]  in_src1,
  input  logic [REG_W-1:0]  in_src2,
  output logic              issue_stall,
  output logic [NUM_FU-1:0] fu_start,
  output logic [NUM_FU-1:0] fu_done
);
  logic                fire, writes_reg;
  logic [FU_W-1:0]     tgt_fu;
  logic [NUM_FU-1:0]   fire_vec, unit_busy;
  logic [NUM_REGS-1:0] reg_pend;
  logic                s1_wait, s2_wait;
  logic [FU_W-1:0]     s1_prod, s2_prod;

  sb_issue_ctl #(
    .N_FU(NUM_FU), .N_REGS(NUM_REGS), .TAG_W(FU_W),
    .RIDX_W(REG_W), .BR_IDX(FU_BR)
  ) u_issue (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_br(in_br),
    .in_fu(in_fu), .in_dst(in_dst), .unit_busy(unit_busy),
    .reg_pend(reg_pend), .br_done(fu_done[FU_BR]), .stall(issue_stall),
    .fire(fire), .writes_reg(writes_reg), .tgt_fu(tgt_fu),
    .fire_vec(fire_vec)
  );

  sb_reg_status #(
    .N_REGS(NUM_REGS), .N_FU(NUM_FU), .TAG_W(FU_W), .RIDX_W(REG_W)
  ) u_regs (
    .clk(clk), .rst(rst), .set_en(writes_reg), .set_reg(in_dst),
    .set_fu(tgt_fu), .done_all(fu_done), .look1_reg(in_src1),
    .look2_reg(in_src2), .look1_wait(s1_wait), .look1_prod(s1_prod),
    .look2_wait(s2_wait), .look2_prod(s2_prod), .reg_pend(reg_pend)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_FU; g++) begin : g_unit
      localparam int LAT = unit_latency(g, MUL_LAT, DIV_LAT, FADD_LAT, BR_LAT);
      sb_unit_slot #(.LAT(LAT), .N_FU(NUM_FU), .TAG_W(FU_W)) u_slot (
        .clk(clk), .rst(rst), .issue(fire_vec[g]),
        .wait1(s1_wait), .prod1(s1_prod), .wait2(s2_wait), .prod2(s2_prod),
        .done_all(fu_done), .busy(unit_busy[g]),
        .start(fu_start[g]), .done(fu_done[g])
      );
    end
  endgenerate

  assert_single_issue_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(unit_busy & ~$past(unit_busy)));

  assert_fire_reserves_R3: assert property (@(posedge clk) disable iff (rst)
    fire |=> $countones(unit_busy & ~$past(unit_busy)) == 1);
endmodule

// File: tb/tb_sb_scoreboard.sv
module tb_sb_scoreboard;
  import sb_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_br = 1'b0;
  logic [FU_W-1:0]  in_fu = '0;
  logic [REG_W-1:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic issue_stall;
  logic [NUM_FU-1:0] fu_start, fu_done;

  sb_scoreboard dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_br(in_br),
    .in_fu(in_fu), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .issue_stall(issue_stall), .fu_start(fu_start), .fu_done(fu_done)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int start_at [NUM_FU];
  int done_at  [NUM_FU];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      for (int f = 0; f < NUM_FU; f++) begin
        if (fu_start[f]) start_at[f] = cyc;
        if (fu_done[f])  done_at[f]  = cyc;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic clear_rec();
    for (int f = 0; f < NUM_FU; f++) begin
      start_at[f] = -1;
      done_at[f]  = -1;
    end
  endtask

  task automatic drain();
    repeat (30) @(negedge clk);
    clear_rec();
  endtask

  // present an instruction, hold it until accepted; returns accepting edge
  task automatic issue(input int fu, input int dst, input int s1, input int s2,
                       input bit br, output int fire, output bit saw_stall);
    in_valid = 1'b1; in_br = br;
    in_fu = FU_W'(fu); in_dst = REG_W'(dst);
    in_src1 = REG_W'(s1); in_src2 = REG_W'(s2);
    saw_stall = 0;
    #1;
    while (issue_stall) begin
      saw_stall = 1;
      @(negedge clk);
      #1;
    end
    fire = cyc + 1;
    @(negedge clk);
    in_valid = 1'b0; in_br = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    clear_rec();
    chk("R9 stall idle", int'(issue_stall), 0);
    chk("R9 start", int'(fu_start), 0);
    chk("R9 done", int'(fu_done), 0);
    in_valid = 1'b1; in_fu = FU_W'(FU_FADD); in_dst = 3'd1;
    #1;
    chk("R9 presented not stalled", int'(issue_stall), 0);
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_indep();
    int f0, f1; bit st;
    issue(FU_FADD, 1, 2, 3, 0, f0, st);
    issue(FU_MUL1, 2, 3, 4, 0, f1, st);
    wait_cyc(f1 + 14);
    chk("R4 fadd start", start_at[FU_FADD], f0);
    chk("R7 fadd latency", done_at[FU_FADD] - start_at[FU_FADD], 4);
    chk("R4 mul start", start_at[FU_MUL1], f1);
    chk("R7 mul latency", done_at[FU_MUL1] - start_at[FU_MUL1], 10);
    drain();
  endtask

  task automatic t_dep();
    int f0, f1; bit st;
    issue(FU_MUL0, 1, 2, 3, 0, f0, st);
    issue(FU_FADD, 4, 1, 5, 0, f1, st);
    chk("R3 unready source no stall", int'(st), 0);
    chk("R3 next edge", f1, f0 + 1);
    wait_cyc(f0 + 20);
    chk("R7 mul done", done_at[FU_MUL0], f0 + 10);
    chk("R5 dependent start", start_at[FU_FADD], done_at[FU_MUL0]);
    drain();
  endtask

  task automatic t_busy();
    int f0, f1, f2; bit st;
    issue(FU_MUL0, 1, 2, 3, 0, f0, st);
    issue(FU_MUL1, 2, 3, 4, 0, f1, st);
    chk("R1 second multiplier free", f1, f0 + 1);
    issue(FU_MUL0, 3, 4, 5, 0, f2, st);
    chk("R1 busy unit stalls", int'(st), 1);
    chk("R1 reissue edge", f2, done_at[FU_MUL0] + 2);
    drain();
  endtask

  task automatic t_waw();
    int f0, f1; bit st;
    issue(FU_DIV, 5, 0, 0, 0, f0, st);
    issue(FU_FADD, 5, 1, 2, 0, f1, st);
    chk("R2 pending dest stalls", int'(st), 1);
    chk("R7 div latency", done_at[FU_DIV], f0 + 16);
    chk("R2 reissue edge", f1, done_at[FU_DIV] + 2);
    drain();
  endtask

  task automatic t_branch();
    int f0, f1, f2; bit st;
    issue(FU_MUL0, 6, 1, 2, 0, f0, st);
    // branch with in_fu pointing at the adder and dst naming the pending r6
    issue(FU_FADD, 6, 6, 0, 1, f1, st);
    chk("R2 branch dst ignored", f1, f0 + 1);
    issue(FU_FADD, 7, 1, 2, 0, f2, st);
    chk("R6 freeze stalls", int'(st), 1);
    chk("R5 branch waits on operand", start_at[FU_BR], done_at[FU_MUL0]);
    chk("R6 routed to branch unit", done_at[FU_BR] - start_at[FU_BR], 2);
    chk("R6 release edge", f2, done_at[FU_BR] + 2);
    wait_cyc(f2 + 6);
    chk("R4 adder after freeze", start_at[FU_FADD], f2);
    drain();
  endtask

  task automatic t_same_cycle();
    int f0, f1; bit st;
    issue(FU_FADD, 1, 0, 0, 0, f0, st);
    wait_cyc(f0 + 4);
    issue(FU_MUL0, 2, 1, 1, 0, f1, st);
    chk("R8 issue edge", f1, f0 + 5);
    chk("R8 producer done cycle", done_at[FU_FADD], f0 + 4);
    wait_cyc(f1 + 12);
    chk("R8 source counted ready", start_at[FU_MUL0], f1);
    drain();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected run end", cyc);
    summary();
  end

  initial begin
    clear_rec();
    t_reset();
    t_indep();
    t_dep();
    t_busy();
    t_waw();
    t_branch();
    t_same_cycle();
    summary();
  end
endmodule